// File: doc/BRIEF.md
# Vector Instruction Fault Checker

This block decides, ahead of execution, whether a packed-integer vector instruction must trap and which trap it takes. Each cycle it looks at the processor mode, the operand width (64 or 128 bits), whether the operand sits in memory and at which address, the segment and canonical-address verdicts produced elsewhere, the relevant control and feature bits, the lock prefix, a pending x87 error, alignment-check enable and the current privilege level.

It reports at most one fault per cycle. When several conditions hold, a fixed priority picks one. The verdict is registered, so it appears on the outputs one clock after the inputs are sampled. Page faults are detected elsewhere and are not part of this block.

Top module: `vfc_fault_checker`

## Requirements
- R1: An undefined-opcode fault is raised whenever the emulation bit `em_i` is 1 or the lock prefix `lock_i` is 1, for any mode and width.
- R2: A 128-bit operation raises an undefined-opcode fault when `osvs_i` is 0. In 64-bit mode (mode 4) a 128-bit operation also raises it when `ext_i` is 0. Outside mode 4, `ext_i` has no effect.
- R3: A device-not-available fault is raised when the task-switched bit `ts_i` is 1.
- R4: A floating-point error fault is raised when `x87_pend_i` is 1, but only for 64-bit operations. A 128-bit operation never reports a floating-point error or an alignment-check fault.
- R5: A 128-bit memory operand whose address has any of bits [3:0] set raises a general-protection fault in every mode.
- R6: In real mode (0) and virtual-8086 mode (1), a memory operand whose last byte (address + 7 for 64-bit, address + 15 for 128-bit) lies above 0xFFFF raises a general-protection fault. In these modes the segment-limit flags and the canonical flag are ignored.
- R7: In protected (2), compatibility (3) and the unused codes 5 to 7:
  - a stack-based reference (`stk_ref_i`=1) with `stk_lim_i`=1 raises a stack fault;
  - a non-stack reference with `seg_lim_i`=1 raises a general-protection fault;
  - the flag that does not match the reference kind is ignored.
- R8: In 64-bit mode (4), a non-canonical address (`canon_i`=0) raises a stack fault for stack-based references and a general-protection fault otherwise. Both segment-limit flags are ignored.
- R9: An alignment-check fault is raised for a 64-bit memory operand when all three hold: `ac_en_i`=1, address bits [2:0] nonzero, and `cpl_i`=3.
- R10: When `mem_i`=0 (register operand), no general-protection, stack or alignment-check fault is raised.
- R11: The fault code encoding is 0 none, 1 undefined-opcode, 2 device-not-available, 3 floating-point error, 4 general-protection, 5 stack, 6 alignment-check.
  - The priority is 1, 2, 3, 4, 5, 6, with the lowest code winning.
  - `fault_valid_o` is 1 exactly when the code is nonzero.
  - Outputs update one clock after the inputs are sampled.
  - Reset (asynchronous, active low) clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode: 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| wide_i | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| mem_i | input | 1 | Operand is in memory |
| addr_i | input | ADDR_W | Effective address of the memory operand |
| seg_lim_i | input | 1 | Data-segment limit violation |
| stk_lim_i | input | 1 | Stack-segment limit violation |
| stk_ref_i | input | 1 | Reference is stack-based |
| canon_i | input | 1 | Address is canonical |
| em_i | input | 1 | Emulation control bit |
| ts_i | input | 1 | Task-switched control bit |
| osvs_i | input | 1 | OS support for saving vector state |
| ext_i | input | 1 | Vector extension supported |
| lock_i | input | 1 | Lock prefix present |
| x87_pend_i | input | 1 | Pending x87 error |
| ac_en_i | input | 1 | Alignment checking enabled |
| cpl_i | input | CPL_W | Current privilege level |
| fault_valid_o | output | 1 | A fault is reported |
| fault_code_o | output | 3 | Fault code per R11 |

## Verification
The hardest cases are those where several fault sources hold at once. Only the ordering can then tell which one wins. Examples are a misaligned 128-bit stack reference that also breaks the stack limit, or a stack fault coinciding with alignment-check conditions.

The vector table builds these overlaps directly, one at a time. It also includes cases that sit exactly on the 0xFFFF boundary for each width, and cases where a flag belongs to the wrong mode or reference kind and must be ignored.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CLS_REAL = 2'd0,
    CLS_PROT = 2'd1,
    CLS_LONG = 2'd2
  } mode_cls_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_NM   = 3'd2,
    FLT_MF   = 3'd3,
    FLT_GP   = 3'd4,
    FLT_SS   = 3'd5,
    FLT_AC   = 3'd6
  } fault_e;

  typedef struct packed {
    logic ud;
    logic nm;
    logic mf;
    logic gp;
    logic ss;
    logic ac;
  } fault_vec_t;
endpackage

// File: rtl/vfc_mode_class.sv
module vfc_mode_class
  import vfc_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_cls_e  cls_o
);
  always_comb begin
    unique case (mode_i)
      MODE_REAL, MODE_V86: cls_o = CLS_REAL;
      MODE_LONG:           cls_o = CLS_LONG;
      default:             cls_o = CLS_PROT;  // protected, compat, unused codes
    endcase
  end
endmodule

// File: rtl/vfc_insn_check.sv
module vfc_insn_check
  import vfc_pkg::*;
(
  input  mode_cls_e cls_i,
  input  logic      wide_i,
  input  logic      em_i,
  input  logic      ts_i,
  input  logic      osvs_i,
  input  logic      ext_i,
  input  logic      lock_i,
  input  logic      x87_pend_i,
  output logic      ud_o,
  output logic      nm_o,
  output logic      mf_o
);
  logic wide_ud;

  // feature gate only checked in 64-bit mode
  assign wide_ud = wide_i & (~osvs_i | ((cls_i == CLS_LONG) & ~ext_i));
  assign ud_o    = em_i | lock_i | wide_ud;
  assign nm_o    = ts_i;
  assign mf_o    = ~wide_i & x87_pend_i;
endmodule

// File: rtl/vfc_mem_check.sv
module vfc_mem_check
  import vfc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 64,
  parameter int unsigned CPL_W        = 2,
  parameter int unsigned WIDE_BYTES   = 16,
  parameter int unsigned NARROW_BYTES = 8,
  parameter int unsigned REAL_TOP     = 32'h0000_FFFF
) (
  input  mode_cls_e         cls_i,
  input  logic              wide_i,
  input  logic              mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg_lim_i,
  input  logic              stk_lim_i,
  input  logic              stk_ref_i,
  input  logic              canon_i,
  input  logic              ac_en_i,
  input  logic [CPL_W-1:0]  cpl_i,
  output logic              gp_o,
  output logic              ss_o,
  output logic              ac_o
);
  localparam int unsigned WIDE_LSB   = $clog2(WIDE_BYTES);
  localparam int unsigned NARROW_LSB = $clog2(NARROW_BYTES);
  localparam logic [ADDR_W:0] TOP_X  = (ADDR_W+1)'(REAL_TOP);
  localparam logic [ADDR_W:0] WIDE_SPAN   = (ADDR_W+1)'(WIDE_BYTES - 1);
  localparam logic [ADDR_W:0] NARROW_SPAN = (ADDR_W+1)'(NARROW_BYTES - 1);

  logic              wide_mis, narrow_mis, real_over;
  logic [ADDR_W:0]   last_byte;
  logic              gp_raw, ss_raw;

  assign wide_mis   = |addr_i[WIDE_LSB-1:0];
  assign narrow_mis = |addr_i[NARROW_LSB-1:0];
  assign last_byte  = {1'b0, addr_i} + (wide_i ? WIDE_SPAN : NARROW_SPAN);
  assign real_over  = last_byte > TOP_X;

  always_comb begin
    gp_raw = wide_i & wide_mis;
    ss_raw = 1'b0;
    unique case (cls_i)
      CLS_REAL: gp_raw = gp_raw | real_over;
      CLS_LONG: begin
        gp_raw = gp_raw | (~canon_i & ~stk_ref_i);
        ss_raw = ~canon_i & stk_ref_i;
      end
      default: begin
        gp_raw = gp_raw | (~stk_ref_i & seg_lim_i);
        ss_raw = stk_ref_i & stk_lim_i;
      end
    endcase
  end

  assign gp_o = mem_i & gp_raw;
  assign ss_o = mem_i & ss_raw;
  assign ac_o = mem_i & ~wide_i & ac_en_i & narrow_mis & (&cpl_i);
endmodule

// File: rtl/vfc_prio.sv
module vfc_prio
  import vfc_pkg::*;
(
  input  fault_vec_t vec_i,
  output fault_e     code_o,
  output logic       any_o
);
  // lowest priority first; later assignments win
  always_comb begin
    code_o = FLT_NONE;
    if (vec_i.ac) code_o = FLT_AC;
    if (vec_i.ss) code_o = FLT_SS;
    if (vec_i.gp) code_o = FLT_GP;
    if (vec_i.mf) code_o = FLT_MF;
    if (vec_i.nm) code_o = FLT_NM;
    if (vec_i.ud) code_o = FLT_UD;
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/vfc_fault_checker.sv
module vfc_fault_checker
  import vfc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CPL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              wide_i,
  input  logic              mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg_lim_i,
  input  logic              stk_lim_i,
  input  logic              stk_ref_i,
  input  logic              canon_i,
  input  logic              em_i,
  input  logic              ts_i,
  input  logic              osvs_i,
  input  logic              ext_i,
  input  logic              lock_i,
  input  logic              x87_pend_i,
  input  logic              ac_en_i,
  input  logic [CPL_W-1:0]  cpl_i,
  output logic              fault_valid_o,
  output logic [2:0]        fault_code_o
);
  mode_cls_e  cls;
  fault_vec_t fv;
  fault_e     code_d, code_q;
  logic       any_d, valid_q, primed_q;

  vfc_mode_class u_cls (.mode_i(mode_i), .cls_o(cls));

  vfc_insn_check u_insn (
    .cls_i(cls), .wide_i(wide_i), .em_i(em_i), .ts_i(ts_i),
    .osvs_i(osvs_i), .ext_i(ext_i), .lock_i(lock_i),
    .x87_pend_i(x87_pend_i),
    .ud_o(fv.ud), .nm_o(fv.nm), .mf_o(fv.mf)
  );

  vfc_mem_check #(.ADDR_W(ADDR_W), .CPL_W(CPL_W)) u_mem (
    .cls_i(cls), .wide_i(wide_i), .mem_i(mem_i), .addr_i(addr_i),
    .seg_lim_i(seg_lim_i), .stk_lim_i(stk_lim_i), .stk_ref_i(stk_ref_i),
    .canon_i(canon_i), .ac_en_i(ac_en_i), .cpl_i(cpl_i),
    .gp_o(fv.gp), .ss_o(fv.ss), .ac_o(fv.ac)
  );

  vfc_prio u_prio (.vec_i(fv), .code_o(code_d), .any_o(any_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= FLT_NONE;
      valid_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      code_q   <= code_d;
      valid_q  <= any_d;
      primed_q <= 1'b1;
    end
  end

  assign fault_code_o  = code_q;
  assign fault_valid_o = valid_q;

  assert_valid_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o == (fault_code_o != 3'd0));

  assert_lock_ud_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(lock_i) |-> fault_code_o == 3'd1);

  assert_reg_no_memfault_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(!mem_i) |-> fault_code_o < 3'd4);

  assert_wide_no_mf_ac_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(wide_i) |-> (fault_code_o != 3'd3) && (fault_code_o != 3'd6));
endmodule

// File: tb/vfc_fault_checker_tb_top.sv
module vfc_fault_checker_tb_top;
  typedef struct packed {
    logic [2:0]  mode;
    logic        wide, mem;
    logic [63:0] addr;
    logic        seg, stk, sref, canon, em, ts, osvs, ext, lock, x87, acen;
    logic [1:0]  cpl;
    logic [2:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // mode wide mem addr seg stk sref canon em ts osvs ext lock x87 acen cpl exp req
  localparam vec_t VECS [31] = '{
    '{3'd2,1,1,64'h1000,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd0,4'd11}, // R11 clean
    '{3'd2,1,1,64'h1000,0,0,0,1,1,0,1,1,0,0,0,2'd0,3'd1,4'd1},  // R1 em
    '{3'd0,0,0,64'h0,   0,0,0,1,0,0,1,1,1,0,0,2'd0,3'd1,4'd1},  // R1 lock
    '{3'd2,1,0,64'h0,   0,0,0,1,0,0,0,1,0,0,0,2'd0,3'd1,4'd2},  // R2 osvs clear
    '{3'd2,0,0,64'h0,   0,0,0,1,0,0,0,1,0,0,0,2'd0,3'd0,4'd2},  // R2 narrow ignores osvs
    '{3'd4,1,0,64'h0,   0,0,0,1,0,0,1,0,0,0,0,2'd0,3'd1,4'd2},  // R2 long ext clear
    '{3'd2,1,0,64'h0,   0,0,0,1,0,0,1,0,0,0,0,2'd0,3'd0,4'd2},  // R2 ext ignored in prot
    '{3'd2,1,0,64'h0,   0,0,0,1,0,1,1,1,0,0,0,2'd0,3'd2,4'd3},  // R3 ts
    '{3'd2,1,0,64'h0,   0,0,0,1,1,1,1,1,0,0,0,2'd0,3'd1,4'd11}, // R11 ud over nm
    '{3'd2,0,0,64'h0,   0,0,0,1,0,0,1,1,0,1,0,2'd0,3'd3,4'd4},  // R4 x87 narrow
    '{3'd2,1,0,64'h0,   0,0,0,1,0,0,1,1,0,1,0,2'd0,3'd0,4'd4},  // R4 x87 wide ignored
    '{3'd0,1,1,64'h1008,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd4,4'd5},  // R5 misaligned real
    '{3'd2,0,1,64'h1004,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd0,4'd9},  // R9 ac disabled
    '{3'd0,0,1,64'hFFF8,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd0,4'd6},  // R6 last byte FFFF
    '{3'd0,0,1,64'hFFF9,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd4,4'd6},  // R6 past FFFF
    '{3'd1,1,1,64'hFFF0,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd0,4'd6},  // R6 v86 wide edge
    '{3'd1,1,1,64'h10000,0,0,0,1,0,0,1,1,0,0,0,2'd0,3'd4,4'd6}, // R6 v86 beyond
    '{3'd0,0,1,64'h100, 1,1,0,0,0,0,1,1,0,0,0,2'd0,3'd0,4'd6},  // R6 flags ignored
    '{3'd2,0,1,64'h100, 0,1,1,1,0,0,1,1,0,0,0,2'd0,3'd5,4'd7},  // R7 stack limit
    '{3'd3,0,1,64'h100, 1,0,0,1,0,0,1,1,0,0,0,2'd0,3'd4,4'd7},  // R7 data limit
    '{3'd2,0,1,64'h100, 1,0,1,1,0,0,1,1,0,0,0,2'd0,3'd0,4'd7},  // R7 wrong flag
    '{3'd4,0,1,64'h100, 0,0,1,0,0,0,1,1,0,0,0,2'd0,3'd5,4'd8},  // R8 noncanon stack
    '{3'd4,0,1,64'h100, 0,0,0,0,0,0,1,1,0,0,0,2'd0,3'd4,4'd8},  // R8 noncanon data
    '{3'd4,0,1,64'h100, 1,1,0,1,0,0,1,1,0,0,0,2'd0,3'd0,4'd8},  // R8 limits ignored
    '{3'd2,0,1,64'h1003,0,0,0,1,0,0,1,1,0,0,1,2'd3,3'd6,4'd9},  // R9 ac
    '{3'd2,0,1,64'h1003,0,0,0,1,0,0,1,1,0,0,1,2'd2,3'd0,4'd9},  // R9 cpl 2
    '{3'd2,0,0,64'h1003,1,0,0,1,0,0,1,1,0,0,1,2'd3,3'd0,4'd10}, // R10 reg no ac/gp
    '{3'd4,1,0,64'h1001,1,1,1,0,0,0,1,1,0,0,0,2'd0,3'd0,4'd10}, // R10 reg wide
    '{3'd2,0,1,64'h100, 1,0,0,1,0,0,1,1,0,1,0,2'd0,3'd3,4'd11}, // R11 mf over gp
    '{3'd2,0,1,64'h1003,0,1,1,1,0,0,1,1,0,0,1,2'd3,3'd5,4'd11}, // R11 ss over ac
    '{3'd2,1,1,64'h1004,0,1,1,1,0,0,1,1,0,0,0,2'd0,3'd4,4'd11}  // R11 gp over ss
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'd2;
  logic        wide_i = 1'b0, mem_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic        seg_lim_i = 1'b0, stk_lim_i = 1'b0, stk_ref_i = 1'b0, canon_i = 1'b1;
  logic        em_i = 1'b0, ts_i = 1'b0, osvs_i = 1'b1, ext_i = 1'b1;
  logic        lock_i = 1'b0, x87_pend_i = 1'b0, ac_en_i = 1'b0;
  logic [1:0]  cpl_i = 2'd0;
  logic        fault_valid_o;
  logic [2:0]  fault_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  vfc_fault_checker dut_i (
    .clk_i, .rst_ni, .mode_i, .wide_i, .mem_i, .addr_i, .seg_lim_i,
    .stk_lim_i, .stk_ref_i, .canon_i, .em_i, .ts_i, .osvs_i, .ext_i,
    .lock_i, .x87_pend_i, .ac_en_i, .cpl_i, .fault_valid_o, .fault_code_o
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp || fault_valid_o !== (exp != 3'd0)) begin
      fails++;
      $display("FAIL %s code=%0d valid=%0b expected code=%0d valid=%0b",
               req, act, fault_valid_o, exp, exp != 3'd0);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i = v.mode; wide_i = v.wide; mem_i = v.mem; addr_i = v.addr;
    seg_lim_i = v.seg; stk_lim_i = v.stk; stk_ref_i = v.sref; canon_i = v.canon;
    em_i = v.em; ts_i = v.ts; osvs_i = v.osvs; ext_i = v.ext;
    lock_i = v.lock; x87_pend_i = v.x87; ac_en_i = v.acen; cpl_i = v.cpl;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    lock_i = 1'b1;
    #3;
    chk("R11 reset", fault_code_o, 3'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 first cycle after reset", fault_code_o, 3'd1);
    // latency: new inputs must not show before the next edge
    @(negedge clk_i); drive(VECS[0]); #1;
    chk("R11 registered latency hold", fault_code_o, 3'd1);
    @(posedge clk_i); #1;
    chk("R11 registered latency update", fault_code_o, 3'd0);

    for (int i = 0; i < 31; i++) begin
      @(negedge clk_i); drive(VECS[i]);
      @(posedge clk_i); #1;
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), fault_code_o, VECS[i].exp);
    end

    // asynchronous reset clears a held fault without a clock edge
    @(negedge clk_i); drive(VECS[1]);
    @(posedge clk_i); #2;
    rst_ni = 1'b0; #1;
    chk("R11 async reset", fault_code_o, 3'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after re-reset", fault_code_o, 3'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule